// File: doc/BRIEF.md
# Paged Segmentation Address Translator

This block turns a virtual address into a physical address in two stages. The top bits of the address pick one of a few segments. Each segment has a descriptor held in registers inside the block: a page-table base address, a highest legal page number and a set of access permissions. The middle bits give a page number. That number is checked against the segment's limit and its permissions before any memory is touched. The block then reads one page-table entry from external memory and combines the entry's frame number with the untouched low offset bits.

A translation is requested with a valid/ready pair. The page-table read goes out on a second valid/ready request channel, and the entry comes back with a response-valid strobe. Every request ends in a single-cycle result. The result is either a physical address or a trap, and a trap carries a cause code: bounds, protection or page fault. Software loads segment descriptors through a dedicated write port.

Top module: `pseg_xlate`

## Requirements
- R1: After synchronous reset, `req_ready` is 1, `out_valid` and `mem_req_valid` are 0, and every segment descriptor has base 0, limit 0 and no permissions.
- R2: The virtual address is split as segment = `req_va[13:12]`, page = `req_va[11:8]`, offset = `req_va[7:0]`. A translation that succeeds reports `out_trap`=0, `out_cause`=0 and `out_pa` = {frame, offset}.
- R3: If the page number is greater than the segment limit, the result is a trap with cause 1 and no memory request is issued. A page equal to the limit is legal. Bounds takes precedence over every other check.
- R4: The access kind `req_kind` is 0 = read, 1 = write, 2 = execute. It needs bit 0, 1 or 2 respectively of the segment permissions. Kind 3 is never permitted. If the segment forbids the access, the result is a trap with cause 2 and no memory request is issued.
- R5: The page-table entry is read from address segment base + page number. `mem_req_valid` stays high with a stable `mem_req_addr` until `mem_req_ready`, and exactly one request is made per translation.
- R6: A page-table entry has bit 11 = present, bits 10:8 = permissions (same bit meaning as R4) and bits 7:0 = frame. An entry that is not present gives a trap with cause 3, which takes precedence over the page permissions.
- R7: A present entry whose permissions forbid the access gives a trap with cause 2.
- R8: `req_ready` is high only while the block is idle. A request presented while a translation is in flight is ignored.
- R9: `out_valid` is a one-cycle pulse. When `out_trap` is 1, `out_pa` is 0.
- R10: `st_we` writes base, limit and permissions of entry `st_idx` at the clock edge and leaves the other entries unchanged. A bounds check made at the same edge uses the previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_we | input | 1 | Segment descriptor write strobe |
| st_idx | input | 2 | Descriptor index to write |
| st_base | input | 10 | Page-table base address |
| st_limit | input | 4 | Highest legal page number |
| st_perm | input | 3 | Segment permissions {exec, write, read} |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block idle, request accepted |
| req_va | input | 14 | Virtual address |
| req_kind | input | 2 | Access kind |
| mem_req_valid | output | 1 | Page-table read request valid |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 10 | Page-table entry address |
| mem_rsp_valid | input | 1 | Page-table entry returned |
| mem_rsp_data | input | 12 | Page-table entry |
| out_valid | output | 1 | Result pulse |
| out_trap | output | 1 | Result is a trap |
| out_cause | output | 2 | 0 none, 1 bounds, 2 protection, 3 page fault |
| out_pa | output | 16 | Physical address |

## Verification
A descriptor write can reach the same clock edge at which an in-flight translation runs its bounds check against that descriptor. The bench provokes this by raising `st_we` for a segment in the very cycle after its request is accepted, while the new descriptor raises the limit. It expects a bounds trap under the old limit. It then repeats the same address and expects the new limit and base to apply, which shows up as a page-table read at the new address. Request handshakes that stall on both the memory request and the response are mixed with all three trap causes and their order of precedence.

// File: rtl/pseg_pkg.sv
package pseg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_BCHK  = 3'd1,
    ST_PREQ  = 3'd2,
    ST_PWAIT = 3'd3,
    ST_DONE  = 3'd4,
    ST_FAULT = 3'd5
  } xl_state_t;

  typedef enum logic [1:0] {
    CZ_NONE  = 2'd0,
    CZ_BOUND = 2'd1,
    CZ_PROT  = 2'd2,
    CZ_PAGE  = 2'd3
  } cause_t;

  localparam int PERM_W = 3;

  // kind 0 read, 1 write, 2 execute, 3 reserved (never allowed)
  function automatic logic perm_allows(input logic [PERM_W-1:0] perm, input logic [1:0] kind);
    case (kind)
      2'd0:    perm_allows = perm[0];
      2'd1:    perm_allows = perm[1];
      2'd2:    perm_allows = perm[2];
      default: perm_allows = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/pseg_segtab.sv
module pseg_segtab
  import pseg_pkg::*;
#(
  parameter int SEG_W  = 2,
  parameter int PAGE_W = 4,
  parameter int BASE_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [SEG_W-1:0]  widx,
  input  logic [BASE_W-1:0] wbase,
  input  logic [PAGE_W-1:0] wlimit,
  input  logic [PERM_W-1:0] wperm,
  input  logic [SEG_W-1:0]  ridx,
  output logic [BASE_W-1:0] rbase,
  output logic [PAGE_W-1:0] rlimit,
  output logic [PERM_W-1:0] rperm
);
  localparam int NSEG = 1 << SEG_W;

  logic [BASE_W-1:0] base_q  [NSEG];
  logic [PAGE_W-1:0] limit_q [NSEG];
  logic [PERM_W-1:0] perm_q  [NSEG];

  for (genvar g = 0; g < NSEG; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst) begin
        base_q[g]  <= '0;
        limit_q[g] <= '0;
        perm_q[g]  <= '0;
      end else if (we && (widx == SEG_W'(g))) begin
        base_q[g]  <= wbase;
        limit_q[g] <= wlimit;
        perm_q[g]  <= wperm;
      end
    end
  end

  assign rbase  = base_q[ridx];
  assign rlimit = limit_q[ridx];
  assign rperm  = perm_q[ridx];

  // R10: a write lands at the next edge
  assert_desc_write_R10: assert property (@(posedge clk) disable iff (rst)
    we |=> (base_q[$past(widx)] == $past(wbase) && limit_q[$past(widx)] == $past(wlimit)
            && perm_q[$past(widx)] == $past(wperm)));

endmodule

// File: rtl/pseg_perm.sv
module pseg_perm
  import pseg_pkg::*;
#(
  parameter int PAGE_W  = 4,
  parameter int FRAME_W = 8
) (
  input  logic [PAGE_W-1:0]          page,
  input  logic [PAGE_W-1:0]          limit,
  input  logic [1:0]                 kind,
  input  logic [PERM_W-1:0]          seg_perm,
  input  logic [FRAME_W+PERM_W:0]    pte,
  output logic                       bnd_fail,
  output logic                       sperm_fail,
  output logic                       pte_absent,
  output logic                       pperm_fail
);
  localparam int PRES_BIT = FRAME_W + PERM_W;

  assign bnd_fail   = page > limit;
  assign sperm_fail = !perm_allows(seg_perm, kind);
  assign pte_absent = !pte[PRES_BIT];
  assign pperm_fail = !perm_allows(pte[FRAME_W +: PERM_W], kind);

endmodule

// File: rtl/pseg_seq.sv
module pseg_seq
  import pseg_pkg::*;
#(
  parameter int SEG_W   = 2,
  parameter int PAGE_W  = 4,
  parameter int OFF_W   = 8,
  parameter int BASE_W  = 10,
  parameter int FRAME_W = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [SEG_W+PAGE_W+OFF_W-1:0] req_va,
  input  logic [1:0]                 req_kind,
  output logic [SEG_W-1:0]           seg_idx,
  output logic [PAGE_W-1:0]          cur_page,
  output logic [1:0]                 cur_kind,
  input  logic [BASE_W-1:0]          seg_base,
  input  logic                       bnd_fail,
  input  logic                       sperm_fail,
  input  logic                       pte_absent,
  input  logic                       pperm_fail,
  output logic                       mem_req_valid,
  input  logic                       mem_req_ready,
  output logic [BASE_W-1:0]          mem_req_addr,
  input  logic                       mem_rsp_valid,
  input  logic [FRAME_W-1:0]         rsp_frame,
  output logic                       out_valid,
  output logic                       out_trap,
  output logic [1:0]                 out_cause,
  output logic [FRAME_W+OFF_W-1:0]   out_pa
);
  localparam int VA_W = SEG_W + PAGE_W + OFF_W;
  localparam int PA_W = FRAME_W + OFF_W;

  xl_state_t         state;
  logic [VA_W-1:0]   va_q;
  logic [1:0]        kind_q;
  logic [BASE_W-1:0] addr_q;
  logic [PA_W-1:0]   pa_q;
  cause_t            cause_q;

  assign seg_idx  = va_q[VA_W-1 -: SEG_W];
  assign cur_page = va_q[OFF_W +: PAGE_W];
  assign cur_kind = kind_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      va_q    <= '0;
      kind_q  <= '0;
      addr_q  <= '0;
      pa_q    <= '0;
      cause_q <= CZ_NONE;
    end else begin
      case (state)
        ST_IDLE: if (req_valid) begin
          va_q   <= req_va;
          kind_q <= req_kind;
          state  <= ST_BCHK;
        end
        ST_BCHK: begin
          if (bnd_fail) begin
            cause_q <= CZ_BOUND;
            pa_q    <= '0;
            state   <= ST_FAULT;
          end else if (sperm_fail) begin
            cause_q <= CZ_PROT;
            pa_q    <= '0;
            state   <= ST_FAULT;
          end else begin
            addr_q <= seg_base + BASE_W'(cur_page);
            state  <= ST_PREQ;
          end
        end
        ST_PREQ: if (mem_req_ready) state <= ST_PWAIT;
        ST_PWAIT: if (mem_rsp_valid) begin
          if (pte_absent) begin
            cause_q <= CZ_PAGE;
            pa_q    <= '0;
            state   <= ST_FAULT;
          end else if (pperm_fail) begin
            cause_q <= CZ_PROT;
            pa_q    <= '0;
            state   <= ST_FAULT;
          end else begin
            cause_q <= CZ_NONE;
            pa_q    <= {rsp_frame, va_q[OFF_W-1:0]};
            state   <= ST_DONE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready     = (state == ST_IDLE);
  assign mem_req_valid = (state == ST_PREQ);
  assign mem_req_addr  = addr_q;
  assign out_valid     = (state == ST_DONE) || (state == ST_FAULT);
  assign out_trap      = (state == ST_FAULT);
  assign out_cause     = cause_q;
  assign out_pa        = pa_q;

  // R3: a bounds failure goes straight to a trap, never to memory
  assert_bound_no_mem_R3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_BCHK && bnd_fail) |=> (out_trap && !mem_req_valid));

  // R5: request held with a stable address until accepted
  assert_req_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R9: result lasts one cycle
  assert_out_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R8: once busy, idle returns only after a result
  assert_busy_R8: assert property (@(posedge clk) disable iff (rst)
    (!req_ready && !out_valid) |=> !req_ready);

  // R6: trap flag and cause code agree
  assert_trap_cause_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_trap == (out_cause != 2'd0)));

  // R9: a trap reports a zero address
  assert_trap_pa_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_trap) |-> (out_pa == '0));

endmodule

// File: rtl/pseg_xlate.sv
module pseg_xlate
  import pseg_pkg::*;
#(
  parameter int SEG_W   = 2,
  parameter int PAGE_W  = 4,
  parameter int OFF_W   = 8,
  parameter int BASE_W  = 10,
  parameter int FRAME_W = 8
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            st_we,
  input  logic [SEG_W-1:0]                st_idx,
  input  logic [BASE_W-1:0]               st_base,
  input  logic [PAGE_W-1:0]               st_limit,
  input  logic [2:0]                      st_perm,
  input  logic                            req_valid,
  output logic                            req_ready,
  input  logic [SEG_W+PAGE_W+OFF_W-1:0]   req_va,
  input  logic [1:0]                      req_kind,
  output logic                            mem_req_valid,
  input  logic                            mem_req_ready,
  output logic [BASE_W-1:0]               mem_req_addr,
  input  logic                            mem_rsp_valid,
  input  logic [FRAME_W+3:0]              mem_rsp_data,
  output logic                            out_valid,
  output logic                            out_trap,
  output logic [1:0]                      out_cause,
  output logic [FRAME_W+OFF_W-1:0]        out_pa
);
  logic [SEG_W-1:0]  seg_idx;
  logic [PAGE_W-1:0] cur_page;
  logic [1:0]        cur_kind;
  logic [BASE_W-1:0] seg_base;
  logic [PAGE_W-1:0] seg_limit;
  logic [PERM_W-1:0] seg_perm;
  logic bnd_fail, sperm_fail, pte_absent, pperm_fail;

  pseg_segtab #(.SEG_W(SEG_W), .PAGE_W(PAGE_W), .BASE_W(BASE_W)) u_tab (
    .clk(clk), .rst(rst), .we(st_we), .widx(st_idx), .wbase(st_base),
    .wlimit(st_limit), .wperm(st_perm), .ridx(seg_idx),
    .rbase(seg_base), .rlimit(seg_limit), .rperm(seg_perm)
  );

  pseg_perm #(.PAGE_W(PAGE_W), .FRAME_W(FRAME_W)) u_perm (
    .page(cur_page), .limit(seg_limit), .kind(cur_kind), .seg_perm(seg_perm),
    .pte(mem_rsp_data), .bnd_fail(bnd_fail), .sperm_fail(sperm_fail),
    .pte_absent(pte_absent), .pperm_fail(pperm_fail)
  );

  pseg_seq #(.SEG_W(SEG_W), .PAGE_W(PAGE_W), .OFF_W(OFF_W), .BASE_W(BASE_W),
             .FRAME_W(FRAME_W)) u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_va(req_va), .req_kind(req_kind), .seg_idx(seg_idx),
    .cur_page(cur_page), .cur_kind(cur_kind), .seg_base(seg_base),
    .bnd_fail(bnd_fail), .sperm_fail(sperm_fail), .pte_absent(pte_absent),
    .pperm_fail(pperm_fail), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .rsp_frame(mem_rsp_data[FRAME_W-1:0]),
    .out_valid(out_valid), .out_trap(out_trap), .out_cause(out_cause),
    .out_pa(out_pa)
  );

endmodule

// File: tb/sim_pseg_xlate.sv
module sim_pseg_xlate;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic st_we = 1'b0;
  logic [1:0] st_idx = '0;
  logic [9:0] st_base = '0;
  logic [3:0] st_limit = '0;
  logic [2:0] st_perm = '0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [13:0] req_va = '0;
  logic [1:0] req_kind = '0;
  logic mem_req_valid;
  logic mem_req_ready = 1'b0;
  logic [9:0] mem_req_addr;
  logic mem_rsp_valid = 1'b0;
  logic [11:0] mem_rsp_data = '0;
  logic out_valid, out_trap;
  logic [1:0] out_cause;
  logic [15:0] out_pa;

  always #4 clk = ~clk;

  pseg_xlate u0 (.*);

  int total = 0;
  int failed = 0;
  logic [11:0] pmem [1024];
  logic [9:0] sbase [4];

  logic [15:0] got_pa;
  logic got_trap, done, addr_stable, busy_ok;
  logic [1:0] got_cause;
  logic [9:0] got_addr;
  int nmem;

  // va | kind | req-ready delay | rsp delay | trap | cause | pa | mem read expected
  localparam int NV = 18;
  localparam logic [39:0] VEC [NV] = '{
    {2'd0,4'd0,8'h12, 2'd0, 2'd0,2'd0, 1'b0,2'd0,16'h3A12, 1'b1},
    {2'd0,4'd0,8'hFF, 2'd1, 2'd1,2'd2, 1'b0,2'd0,16'h3AFF, 1'b1},
    {2'd0,4'd1,8'h00, 2'd0, 2'd2,2'd0, 1'b0,2'd0,16'h4400, 1'b1},
    {2'd0,4'd1,8'h00, 2'd1, 2'd0,2'd1, 1'b1,2'd2,16'h0000, 1'b1},
    {2'd0,4'd2,8'h00, 2'd0, 2'd0,2'd0, 1'b1,2'd3,16'h0000, 1'b1},
    {2'd0,4'd3,8'h00, 2'd0, 2'd1,2'd1, 1'b1,2'd2,16'h0000, 1'b1},
    {2'd0,4'd3,8'h80, 2'd2, 2'd0,2'd0, 1'b0,2'd0,16'h9C80, 1'b1},
    {2'd0,4'd4,8'h00, 2'd0, 2'd0,2'd0, 1'b1,2'd1,16'h0000, 1'b0},
    {2'd1,4'd15,8'h01,2'd0, 2'd3,2'd3, 1'b0,2'd0,16'hC101, 1'b1},
    {2'd1,4'd15,8'h01,2'd1, 2'd0,2'd0, 1'b1,2'd2,16'h0000, 1'b0},
    {2'd2,4'd0,8'h33, 2'd2, 2'd0,2'd1, 1'b0,2'd0,16'h0733, 1'b1},
    {2'd2,4'd1,8'h00, 2'd0, 2'd0,2'd0, 1'b1,2'd1,16'h0000, 1'b0},
    {2'd3,4'd0,8'h00, 2'd0, 2'd0,2'd0, 1'b1,2'd2,16'h0000, 1'b0},
    {2'd0,4'd0,8'h00, 2'd3, 2'd0,2'd0, 1'b1,2'd2,16'h0000, 1'b0},
    {2'd2,4'd0,8'h00, 2'd1, 2'd0,2'd0, 1'b1,2'd2,16'h0000, 1'b0},
    {2'd1,4'd15,8'h00,2'd2, 2'd0,2'd0, 1'b1,2'd2,16'h0000, 1'b0},
    {2'd3,4'd1,8'h00, 2'd0, 2'd0,2'd0, 1'b1,2'd1,16'h0000, 1'b0},
    {2'd1,4'd0,8'h00, 2'd0, 2'd1,2'd0, 1'b1,2'd3,16'h0000, 1'b1}
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr_seg(input logic [1:0] idx, input logic [9:0] b, input logic [3:0] lim, input logic [2:0] p);
    @(negedge clk);
    st_we = 1'b1; st_idx = idx; st_base = b; st_limit = lim; st_perm = p;
    sbase[idx] = b;
    @(negedge clk);
    st_we = 1'b0;
  endtask

  task automatic xlate(input logic [13:0] va, input logic [1:0] kind, input int rdly,
                       input int sdly, input bit hold_busy);
    int phase;
    int cnt;
    logic [9:0] a0;
    done = 1'b0; nmem = 0; addr_stable = 1'b1; busy_ok = 1'b1; a0 = '0;
    got_pa = '0; got_trap = 1'b0; got_cause = '0; got_addr = '0;
    @(negedge clk);
    req_valid = 1'b1; req_va = va; req_kind = kind;
    @(negedge clk);
    if (hold_busy) begin req_va = va ^ 14'h3FFF; req_kind = 2'd0; end
    else req_valid = 1'b0;
    phase = 0; cnt = 0;
    for (int guard = 0; guard < 60 && !done; guard++) begin
      if (phase == 3) begin mem_rsp_valid = 1'b0; phase = 4; end
      if (phase == 1) begin mem_req_ready = 1'b0; phase = 2; cnt = 0; end
      if (hold_busy && req_ready) busy_ok = 1'b0;
      if (out_valid) begin
        got_pa = out_pa; got_trap = out_trap; got_cause = out_cause;
        done = 1'b1; req_valid = 1'b0;
      end else begin
        if (phase == 0 && mem_req_valid) begin
          if (cnt == 0) a0 = mem_req_addr;
          else if (mem_req_addr !== a0) addr_stable = 1'b0;
          if (cnt == rdly) begin mem_req_ready = 1'b1; phase = 1; nmem++; got_addr = a0; end
          else cnt++;
        end else if (phase >= 2 && mem_req_valid) begin
          nmem++;
        end
        if (phase == 2) begin
          if (cnt == sdly) begin
            mem_rsp_valid = 1'b1; mem_rsp_data = pmem[got_addr]; phase = 3;
          end else cnt++;
        end
        @(negedge clk);
      end
    end
    req_valid = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    failed++; total++;
    $display("FAIL R8 watchdog: actual=hung expected=finished");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) pmem[i] = '0;
    for (int i = 0; i < 4; i++) sbase[i] = '0;
    pmem[10'h010] = 12'hF3A;
    pmem[10'h011] = 12'h944;
    pmem[10'h012] = 12'h055;
    pmem[10'h013] = 12'hE9C;
    pmem[10'h10F] = 12'hFC1;
    pmem[10'h200] = 12'hD07;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state at the ports
    chk("R1", "req_ready", 32'(req_ready), 32'd1);
    chk("R1", "out_valid", 32'(out_valid), 32'd0);
    chk("R1", "mem_req_valid", 32'(mem_req_valid), 32'd0);

    wr_seg(2'd0, 10'h010, 4'd3, 3'b111);
    wr_seg(2'd1, 10'h100, 4'd15, 3'b001);
    wr_seg(2'd2, 10'h200, 4'd0, 3'b101);

    // table walk: R2 R3 R4 R5 R6 R7 R9, segment 3 left at reset values (R1)
    for (int v = 0; v < NV; v++) begin
      xlate(VEC[v][39:26], VEC[v][25:24], int'(VEC[v][23:22]), int'(VEC[v][21:20]), 1'b0);
      chk("R9", $sformatf("v%0d done", v), 32'(done), 32'd1);
      chk("R3 R4 R6 R7", $sformatf("v%0d trap", v), 32'(got_trap), 32'(VEC[v][19]));
      chk("R3 R4 R6 R7", $sformatf("v%0d cause", v), 32'(got_cause), 32'(VEC[v][18:17]));
      chk("R2 R9", $sformatf("v%0d pa", v), 32'(got_pa), 32'(VEC[v][16:1]));
      chk("R3 R4 R5", $sformatf("v%0d reads", v), 32'(nmem), 32'(VEC[v][0]));
      if (VEC[v][0]) begin
        chk("R5", $sformatf("v%0d addr", v), 32'(got_addr),
            32'(sbase[VEC[v][39:38]] + 10'(VEC[v][37:34])));
        chk("R5", $sformatf("v%0d addr hold", v), 32'(addr_stable), 32'd1);
      end
      @(negedge clk);
      chk("R9", $sformatf("v%0d pulse", v), 32'(out_valid), 32'd0);
      chk("R8", $sformatf("v%0d idle", v), 32'(req_ready), 32'd1);
    end

    // R8: requests held during a busy translation are ignored
    xlate({2'd0, 4'd1, 8'h5A}, 2'd0, 3, 3, 1'b1);
    chk("R8", "busy ready low", 32'(busy_ok), 32'd1);
    chk("R8", "busy result pa", 32'(got_pa), 32'h445A);
    chk("R8", "busy single read", 32'(nmem), 32'd1);
    @(negedge clk);
    chk("R8", "busy no second result", 32'(out_valid), 32'd0);
    chk("R8", "busy back idle", 32'(req_ready), 32'd1);

    // R10: descriptor write at the same edge as the bounds check
    @(negedge clk);
    req_valid = 1'b1; req_va = {2'd2, 4'd1, 8'h00}; req_kind = 2'd0;
    @(negedge clk);
    req_valid = 1'b0;
    st_we = 1'b1; st_idx = 2'd2; st_base = 10'h240; st_limit = 4'd15; st_perm = 3'b101;
    sbase[2] = 10'h240;
    @(negedge clk);
    st_we = 1'b0;
    chk("R10", "same-edge result", 32'(out_valid), 32'd1);
    chk("R10", "same-edge old limit", 32'(out_cause), 32'd1);
    chk("R10", "same-edge no read", 32'(mem_req_valid), 32'd0);
    xlate({2'd2, 4'd1, 8'h00}, 2'd0, 0, 0, 1'b0);
    chk("R10", "new limit cause", 32'(got_cause), 32'd3);
    chk("R10", "new base addr", 32'(got_addr), 32'h241);
    xlate({2'd0, 4'd0, 8'h77}, 2'd2, 0, 0, 1'b0);
    chk("R10", "other entry intact", 32'(got_pa), 32'h3A77);

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

endmodule